// File: doc/BRIEF.md
# Serial Register Port for a Sampled-Data Converter

This block is the device side of a three-wire serial port (clock, active-low select, data in) with one shared output line. That output line carries register data during reads and shows a conversion-ready flag the rest of the time. A host first sends an 8-bit command byte. The byte names one of four registers (status, mode, filter, 24-bit result) and says whether the next transfer reads or writes it. The block then shifts that transfer in or out and goes back to waiting for a command. A continuous-read mode pushes each new result out on the next 24 serial clocks with no command. A run of 32 ones on the data input restores every register.

All pins are sampled with the system clock `clk`. The serial clock is oversampled, so it must stay at each level for at least two `clk` periods. Conversion results arrive on a valid/ready stream. `res_ready` drops while the result register is being shifted out, so a new result can never overwrite a word in transit. The producer must hold `res_valid` and `res_data` steady until it sees `res_ready` high at a clock edge. A handshake completes when both signals are high at the same `clk` edge.

Top module: `sif_serial_port`

## Requirements
- R1: After reset, the status, mode, filter and result registers read 0x8C, 0x02, 0x04 and 0x000000. `cfg_mode` reads 0x02 and `cfg_filter` reads 0x04.
- R2: While the interface waits for a command, a 1 on `din` as the first bit is skipped. The byte starts at the first 0. Command byte, MSB first: bit 7 must be 0, bit 6 must be 0, bits 5:4 select the register (00 status, 01 mode, 10 filter, 11 result), bit 3 is 1 for read, bit 2 is the continuous-read request, bits 1:0 are the channel.
- R3: Mode (command 0x10 write, 0x18 read) and filter (0x20 write, 0x28 read) are 8-bit registers that can be read and written. After each transfer the port waits for a command again.
- R4: Misuse is dropped. A command with bit 6 set is discarded, and the next byte is taken as a new command. A mode write with any of bits 5, 4 or 0 set is ignored. A filter write with any of bits 7, 6 or 3 set is ignored. Writes to the status or result register change nothing.
- R5: When `din` is high on 32 consecutive serial-clock falling edges, all registers return to their reset values and the port waits for a command. This counter takes priority over any decoding in progress.
- R6: Read data goes out MSB first. Each bit changes after a serial-clock falling edge and is held until the next falling edge. `dout_en` is high exactly when `cs_n` is low.
- R7: An accepted result clears the ready flag. The flag is status bit 7, and `dout` shows it when no data bit is being presented. `res_ready` is low while the result register is being shifted out.
- R8: Completing a normal result read sets the ready flag. Reading the result again returns the same word.
- R9: Command 0x3C or 0x3D enters continuous read. Each accepted result is shifted out once on the next 24 falling edges. After that, `dout` stays at the high ready level until a new result arrives.
- R10: In continuous read, a byte 001110xx clocked in on `din` during the first 8 bits of a pending result leaves the mode. The result stays unread, and normal commands work again.
- R11: Raising `cs_n` in the middle of a byte discards the partial bits and returns the port to waiting for a command.
- R12: A valid mode write sets the ready flag.
- R13: The channel bits of every accepted command drive `cfg_chan` and appear in status bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial data in, taken at sclk falling edges |
| dout | output | 1 | Serial data out, or the ready flag (low when a result is pending) |
| dout_en | output | 1 | Output drive enable; high-impedance when low |
| res_valid | input | 1 | Conversion result offered |
| res_ready | output | 1 | Result can be accepted |
| res_data | input | 24 | Conversion result word |
| cfg_mode | output | 8 | Current mode register |
| cfg_filter | output | 8 | Current filter register |
| cfg_chan | output | 2 | Current channel selection |

## Verification
The command decoder is tried with clean bytes, bytes preceded by idle ones, bytes with the reserved bit set, and bytes cut short by `cs_n`. These cases separate correct bit alignment from a decoder that counts from the wrong edge or keeps stale bits. Result words with alternating and irregular bit patterns show whether the order of bits and each bit position are correct. The same words are read once in normal mode and once in continuous mode, and the exit byte is sent mid-stream. These cases separate single-delivery streaming from repeat reads and show the ready flag at each point. A 32-bit run of ones after a nondefault mode write shows that the reset restores configuration and not just the state machine.

// File: rtl/sif_pkg.sv
package sif_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} st_e;
  typedef enum logic [1:0] {SEL_STAT = 2'b00, SEL_MODE = 2'b01,
                            SEL_FILT = 2'b10, SEL_DATA = 2'b11} sel_e;
  localparam logic [7:0] MODE_RST = 8'h02;
  localparam logic [7:0] FILT_RST = 8'h04;
  localparam logic [7:0] MODE_RSV = 8'h31;  // bits that must stay zero
  localparam logic [7:0] FILT_RSV = 8'hC8;
  localparam logic [5:0] CRD_EXIT = 6'b001110;
endpackage

// File: rtl/sif_sample.sv
module sif_sample #(
  parameter int ONES_LIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic fall,
  output logic soft_rst
);
  localparam int OW = $clog2(ONES_LIM + 1);

  logic          sclk_q;
  logic [OW-1:0] ones;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;

  assign fall     = sclk_q & ~sclk & ~cs_n;
  assign soft_rst = fall & din & (ones == OW'(ONES_LIM - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ones <= '0;
    else if (cs_n || soft_rst) ones <= '0;
    else if (fall)             ones <= din ? ones + 1'b1 : '0;

  assert_ones_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ones < OW'(ONES_LIM));
  assert_ones_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ones == '0));
endmodule

// File: rtl/sif_regs.sv
module sif_regs
  import sif_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_mode,
  input  logic              wr_filt,
  input  logic [7:0]        wr_val,
  input  logic              chan_we,
  input  logic [1:0]        chan_val,
  input  logic              set_rdy,
  input  logic              busy,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic [7:0]        mode_q,
  output logic [7:0]        filt_q,
  output logic [DATA_W-1:0] data_q,
  output logic              rdy_n,
  output logic [1:0]        chan_q
);
  logic accept;
  assign res_ready = ~busy;
  assign accept    = res_valid & res_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= MODE_RST; filt_q <= FILT_RST; data_q <= '0;
      rdy_n  <= 1'b1;     chan_q <= 2'b00;
    end else if (soft_rst) begin
      mode_q <= MODE_RST; filt_q <= FILT_RST; data_q <= '0;
      rdy_n  <= 1'b1;     chan_q <= 2'b00;
    end else begin
      if (wr_mode) mode_q <= wr_val;
      if (wr_filt) filt_q <= wr_val;
      if (chan_we) chan_q <= chan_val;
      if (accept) begin
        data_q <= res_data;
        rdy_n  <= 1'b0;
      end else if (set_rdy) begin
        rdy_n  <= 1'b1;
      end
    end

  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == MODE_RST && filt_q == FILT_RST && rdy_n));
  assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !soft_rst) |=> !rdy_n);
  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst) |=> $stable(data_q));
endmodule

// File: rtl/sif_ctrl.sv
module sif_ctrl
  import sif_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              din,
  input  logic              fall,
  input  logic              soft_rst,
  input  logic [7:0]        mode_q,
  input  logic [7:0]        filt_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic              rdy_n,
  output logic              wr_mode,
  output logic              wr_filt,
  output logic [7:0]        wr_val,
  output logic              chan_we,
  output logic [1:0]        chan_val,
  output logic              set_rdy,
  output logic              busy,
  output logic              dout
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LASTB = CW'(DATA_W - 1);
  localparam logic [CW-1:0] BYTEB = CW'(7);

  st_e              st;
  sel_e             sel;
  logic [CW-1:0]    cnt, rd_len, bidx;
  logic [6:0]       rx;
  logic [DATA_W-1:0] tx;
  logic             cread, hold, dbit;
  logic [7:0]       byte_in, stat8, val8;
  logic             last8;

  assign byte_in = {rx, din};
  assign last8   = (cnt == BYTEB);
  assign bidx    = LASTB - cnt;
  assign stat8   = {rdy_n, 1'b0, 2'b00, 2'b11, byte_in[1:0]};
  assign wr_val  = byte_in;
  assign chan_val = byte_in[1:0];
  assign busy    = (st == ST_RD && sel == SEL_DATA) || (cread && cnt != '0);
  assign dout    = hold ? dbit : rdy_n;

  always_comb
    case (byte_in[5:4])
      2'b00:   val8 = stat8;
      2'b01:   val8 = mode_q;
      default: val8 = filt_q;
    endcase

  always_comb begin
    wr_mode = 1'b0; wr_filt = 1'b0; chan_we = 1'b0; set_rdy = 1'b0;
    if (fall && !soft_rst)
      case (st)
        ST_CMD:
          if (!cread) chan_we = last8 && !byte_in[6];
          else if (!rdy_n && cnt == LASTB) set_rdy = 1'b1;
        ST_WR:
          if (last8) begin
            if (sel == SEL_MODE && (byte_in & MODE_RSV) == 8'h00) begin
              wr_mode = 1'b1; set_rdy = 1'b1;
            end
            if (sel == SEL_FILT && (byte_in & FILT_RSV) == 8'h00) wr_filt = 1'b1;
          end
        ST_RD:
          if (sel == SEL_DATA && cnt == rd_len - 1'b1) set_rdy = 1'b1;
        default: ;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || soft_rst) begin
      st <= ST_CMD; sel <= SEL_STAT; cnt <= '0; rd_len <= '0; rx <= '0;
      tx <= '0; cread <= 1'b0; hold <= 1'b0; dbit <= 1'b1;
    end else if (cs_n) begin
      st <= ST_CMD; cnt <= '0; hold <= 1'b0;
    end else if (fall) begin
      case (st)
        ST_CMD:
          if (cread) begin
            if (!rdy_n) begin
              hold <= 1'b1;
              dbit <= data_q[bidx];
              rx   <= byte_in[6:0];
              if (last8 && byte_in[7:2] == CRD_EXIT) begin
                cread <= 1'b0; cnt <= '0;
              end else if (cnt == LASTB) cnt <= '0;
              else cnt <= cnt + 1'b1;
            end else hold <= 1'b0;
          end else begin
            hold <= 1'b0;
            if (cnt == '0 && din) begin
              cnt <= '0;                       // idle one before the byte
            end else if (!last8) begin
              rx <= byte_in[6:0]; cnt <= cnt + 1'b1;
            end else begin
              cnt <= '0;
              if (!byte_in[6]) begin
                sel <= sel_e'(byte_in[5:4]);
                if (byte_in[3]) begin
                  if (byte_in[5:4] == 2'b11 && byte_in[2]) cread <= 1'b1;
                  else begin
                    st <= ST_RD;
                    if (byte_in[5:4] == 2'b11) begin
                      rd_len <= CW'(DATA_W); tx <= data_q;
                    end else begin
                      rd_len <= CW'(8); tx <= {val8, {(DATA_W-8){1'b0}}};
                    end
                  end
                end else if (byte_in[5:4] == 2'b01 || byte_in[5:4] == 2'b10)
                  st <= ST_WR;
              end
            end
          end
        ST_WR: begin
          hold <= 1'b0;
          rx   <= byte_in[6:0];
          if (last8) begin cnt <= '0; st <= ST_CMD; end
          else cnt <= cnt + 1'b1;
        end
        ST_RD: begin
          hold <= 1'b1;
          dbit <= tx[DATA_W-1];
          tx   <= tx << 1;
          if (cnt == rd_len - 1'b1) begin cnt <= '0; st <= ST_CMD; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= ST_CMD;
      endcase
    end

  assert_cs_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == ST_CMD && cnt == '0));
  assert_bit_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(dbit));
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LASTB);
  assert_cread_no_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cread |-> (st != ST_RD));
endmodule

// File: rtl/sif_serial_port.sv
module sif_serial_port #(
  parameter int DATA_W   = 24,
  parameter int ONES_LIM = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic [7:0]        cfg_mode,
  output logic [7:0]        cfg_filter,
  output logic [1:0]        cfg_chan
);
  logic              fall, soft_rst, wr_mode, wr_filt, chan_we, set_rdy, busy, rdy_n;
  logic [7:0]        wr_val;
  logic [1:0]        chan_val;
  logic [DATA_W-1:0] data_q;

  assign dout_en = ~cs_n;

  sif_sample #(.ONES_LIM(ONES_LIM)) u_sample (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .fall(fall), .soft_rst(soft_rst));

  sif_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_mode(wr_mode),
    .wr_filt(wr_filt), .wr_val(wr_val), .chan_we(chan_we), .chan_val(chan_val),
    .set_rdy(set_rdy), .busy(busy), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .mode_q(cfg_mode), .filt_q(cfg_filter), .data_q(data_q),
    .rdy_n(rdy_n), .chan_q(cfg_chan));

  sif_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .fall(fall),
    .soft_rst(soft_rst), .mode_q(cfg_mode), .filt_q(cfg_filter), .data_q(data_q),
    .rdy_n(rdy_n), .wr_mode(wr_mode), .wr_filt(wr_filt), .wr_val(wr_val),
    .chan_we(chan_we), .chan_val(chan_val), .set_rdy(set_rdy), .busy(busy),
    .dout(dout));
endmodule

// File: tb/sif_serial_port_tb_top.sv
module sif_serial_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic res_valid = 1'b0;
  logic [23:0] res_data = '0;
  logic dout, dout_en, res_ready;
  logic [7:0] cfg_mode, cfg_filter;
  logic [1:0] cfg_chan;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [23:0] exp_q[$], act_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sif_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_en(dout_en), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .cfg_mode(cfg_mode), .cfg_filter(cfg_filter),
    .cfg_chan(cfg_chan));

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: pops expected against produced words
  always @(negedge clk)
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());

  task automatic shift(input int n, input logic [31:0] bits, output logic [31:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i]; sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      got = {got[30:0], dout};
    end
    din = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    logic [31:0] g;
    shift(8, {24'h0, b}, g);
  endtask

  task automatic rd_reg(input string req, input logic [7:0] c, input int n, input logic [23:0] e);
    logic [31:0] g;
    send(c);
    exp_q.push_back(e); tag_q.push_back(req);
    shift(n, 32'h0, g);
    act_q.push_back(g[23:0]);
  endtask

  task automatic wr_reg(input logic [7:0] c, input logic [7:0] v);
    send(c); send(v);
  endtask

  task automatic push_res(input logic [23:0] v);
    @(negedge clk);
    res_valid = 1'b1; res_data = v;
    @(posedge clk);
    while (!res_ready) @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] g1, g2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state, R6 deselected output
    check("R1 mode", {16'h0, cfg_mode}, 24'h02);
    check("R1 filter", {16'h0, cfg_filter}, 24'h04);
    check("R6 hiz", {23'h0, dout_en}, 24'h0);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    check("R6 enable", {23'h0, dout_en}, 24'h1);
    rd_reg("R1 status", 8'h08, 8, 24'h8C);
    rd_reg("R1 mode rd", 8'h18, 8, 24'h02);
    rd_reg("R1 filter rd", 8'h28, 8, 24'h04);
    rd_reg("R1 data", 8'h38, 24, 24'h000000);
    // R2 idle ones before the command
    shift(3, 32'h7, g1);
    rd_reg("R2 lead ones", 8'h18, 8, 24'h02);
    // R3 writes and reads
    wr_reg(8'h10, 8'h84);
    rd_reg("R3 mode", 8'h18, 8, 24'h84);
    check("R3 cfg_mode", {16'h0, cfg_mode}, 24'h84);
    wr_reg(8'h20, 8'h32);
    rd_reg("R3 filter", 8'h28, 8, 24'h32);
    // R4 misuse dropped
    wr_reg(8'h10, 8'h01);
    check("R4 mode rsv", {16'h0, cfg_mode}, 24'h84);
    wr_reg(8'h20, 8'h08);
    check("R4 filt rsv", {16'h0, cfg_filter}, 24'h32);
    send(8'h50); send(8'h00);
    rd_reg("R4 bit6 cmd", 8'h18, 8, 24'h84);
    wr_reg(8'h30, 8'hFF);
    rd_reg("R4 data wr", 8'h38, 24, 24'h000000);
    // R7 result accepted clears ready
    check("R7 ready idle", {23'h0, res_ready}, 24'h1);
    push_res(24'hA5C3E1);
    rd_reg("R7 status", 8'h08, 8, 24'h0C);
    cs_n = 1'b1; repeat (2) @(negedge clk);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    check("R7 pin low", {23'h0, dout}, 24'h0);
    // R8 read, ready set, reread; R7 back-pressure mid read
    send(8'h38);
    shift(12, 32'h0, g1);
    check("R7 busy read", {23'h0, res_ready}, 24'h0);
    shift(12, 32'h0, g2);
    exp_q.push_back(24'hA5C3E1); tag_q.push_back("R8 data");
    act_q.push_back({g1[11:0], g2[11:0]});
    rd_reg("R8 status", 8'h08, 8, 24'h8C);
    rd_reg("R8 reread", 8'h38, 24, 24'hA5C3E1);
    // R13 channel
    rd_reg("R13 status ch", 8'h09, 8, 24'h8D);
    check("R13 cfg_chan", {22'h0, cfg_chan}, 24'h1);
    // R12 mode write sets ready
    push_res(24'h123456);
    rd_reg("R12 pending", 8'h08, 8, 24'h0C);
    wr_reg(8'h10, 8'h00);
    rd_reg("R12 status", 8'h08, 8, 24'h8C);
    // R9 continuous read
    send(8'h3C);
    push_res(24'h89ABCD);
    exp_q.push_back(24'h89ABCD); tag_q.push_back("R9 stream");
    shift(24, 32'h0, g1); act_q.push_back(g1[23:0]);
    shift(1, 32'h0, g1);
    shift(8, 32'h0, g1);
    check("R9 once", g1[23:0], 24'h0000FF);
    push_res(24'h0F0F0F);
    shift(10, 32'h0, g1);
    check("R7 busy stream", {23'h0, res_ready}, 24'h0);
    shift(14, 32'h0, g2);
    exp_q.push_back(24'h0F0F0F); tag_q.push_back("R9 stream2");
    act_q.push_back({g1[9:0], g2[13:0]});
    // R10 exit while ready low
    push_res(24'h555555);
    shift(8, 32'h38, g1);
    check("R10 exit bits", g1[23:0], 24'h000055);
    rd_reg("R10 status", 8'h08, 8, 24'h0C);
    rd_reg("R10 data", 8'h38, 24, 24'h555555);
    // R11 chip select abort
    shift(4, 32'h1, g1);
    cs_n = 1'b1; repeat (3) @(negedge clk);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    rd_reg("R11 abort", 8'h18, 8, 24'h00);
    // R5 ones reset
    wr_reg(8'h10, 8'h84);
    check("R5 pre", {16'h0, cfg_mode}, 24'h84);
    shift(32, 32'hFFFF_FFFF, g1);
    check("R5 mode", {16'h0, cfg_mode}, 24'h02);
    check("R5 filter", {16'h0, cfg_filter}, 24'h04);
    rd_reg("R5 status", 8'h08, 8, 24'h8C);
    // R6 deselect
    cs_n = 1'b1; repeat (2) @(negedge clk);
    check("R6 hiz end", {23'h0, dout_en}, 24'h0);
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_up();
  end
endmodule